// File: doc/BRIEF.md
# ROM-Signature Self-Test Sequencer

This block is the built-in self-test controller of a small peripheral. A one-cycle start command carries a result address. When that command arrives, the sequencer first pulses a selective internal reset. It then streams every word of an internal ROM into a 16-bit multiple-input signature register and compares the final value with a golden signature fixed at build time. Next it exercises each word of an internal register bank with two check patterns. It then hands a diagnose request to the serial subsystem and waits, with a timeout, for a pass or fail reply.

When the three checks are done, the block issues one 32-bit memory write to the captured address. The upper half of that word is the raw signature and the lower half is a status word with fixed fail bits. The write is followed by a one-cycle full device reset, and the block returns to idle. The ROM, the register bank and the diagnose responder all sit outside the block and are reached through plain strobe-and-data pins.

Top module: `bist_seq`

## Requirements
- R1: An accepted start is followed, in the next cycle, by a single one-cycle `sel_rst` pulse. No ROM read and no register write happens before that pulse.
- R2: ROM words are read one per cycle on consecutive cycles, at addresses 0 through ROM_DEPTH-1 in increasing order, with `rom_rd` high on each read.
- R3: The signature starts from 16'hFFFF at the selective reset. On each ROM read it becomes ((s<<1) XOR (s[15] ? 16'h1021 : 0)) XOR word. The final value is written in bits 31:16 of the result word.
- R4: Status bit 2 is 1 exactly when the final signature differs from GOLDEN.
- R5: Registers are tested in index order from 0 to REG_COUNT-1. Each register is written with 16'hAAAA and read back on the next cycle, then written with 16'h5555 and read back, before the next register. Any read-back mismatch sets status bit 3.
- R6: After the register checks, `diag_req` pulses for exactly one cycle. If the reply arrives with `diag_fail`=1, status bit 5 is set; a reply with `diag_fail`=0 leaves it clear.
- R7: The wait begins in the cycle after `diag_req` and lasts at most TIMEOUT cycles. A reply in the last of those cycles is honoured. If no reply arrives in the window, status bit 5 is set.
- R8: Status bit 12 equals the OR of bits 5, 3 and 2. Every other bit of the lower half is 0. A status bit of 0 means pass.
- R9: Exactly one `wr_en` pulse carries the result word to the address captured with the start. `dev_rst` pulses in the following cycle, and `busy` is low in the cycle after that.
- R10: A start that arrives while `busy` is high is ignored. The run in progress keeps its address and produces a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command strobe |
| start_addr | input | AW | Result address carried by the start |
| busy | output | 1 | High while a test run is in progress |
| sel_rst | output | 1 | Selective internal reset pulse |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | clog2(ROM_DEPTH) | ROM word address |
| rom_data | input | 16 | ROM word for `rom_addr`, same cycle |
| reg_we | output | 1 | Register-bank write strobe |
| reg_idx | output | clog2(REG_COUNT) | Register index under test |
| reg_wdata | output | 16 | Check pattern being written |
| reg_rdata | input | 16 | Read-back of register `reg_idx`, same cycle |
| diag_req | output | 1 | Diagnose request pulse |
| diag_done | input | 1 | Diagnose reply strobe |
| diag_fail | input | 1 | Reply result, 1 = fail |
| wr_en | output | 1 | Result memory-write strobe |
| wr_addr | output | AW | Result address |
| wr_data | output | 32 | Signature (31:16) and status (15:0) |
| dev_rst | output | 1 | Full device reset pulse |

## Verification
Two events can meet in one cycle: a diagnose reply and the expiry of the wait window. The bench provokes this by timing its responder so that a passing reply lands exactly in the final wait cycle. The result must then show bit 5 clear. The same reply moved one cycle later must instead be treated as a timeout. Both cases are judged on the status half of the single result write.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELRST,
        ST_ROM,
        ST_REG_WR,
        ST_REG_RD,
        ST_DIAG_REQ,
        ST_DIAG_WAIT,
        ST_WRITE,
        ST_DEVRST
    } bist_state_e;

    localparam int unsigned BIT_OVERALL = 12;
    localparam int unsigned BIT_DIAG    = 5;
    localparam int unsigned BIT_REG     = 3;
    localparam int unsigned BIT_ROM     = 2;

    localparam logic [15:0] MISR_POLY = 16'h1021;
    localparam logic [15:0] MISR_SEED = 16'hFFFF;
    localparam logic [15:0] PAT_A     = 16'hAAAA;
    localparam logic [15:0] PAT_B     = 16'h5555;

    typedef struct packed {
        logic diag_fail;
        logic reg_fail;
        logic rom_fail;
    } bist_flags_t;

    function automatic logic [15:0] misr_step(input logic [15:0] s, input logic [15:0] d);
        return ({s[14:0], 1'b0} ^ (s[15] ? MISR_POLY : 16'h0000)) ^ d;
    endfunction

    function automatic logic [15:0] pack_status(input bist_flags_t f);
        logic [15:0] w;
        w = '0;
        w[BIT_ROM]     = f.rom_fail;
        w[BIT_REG]     = f.reg_fail;
        w[BIT_DIAG]    = f.diag_fail;
        w[BIT_OVERALL] = f.rom_fail | f.reg_fail | f.diag_fail;
        return w;
    endfunction

endpackage

// File: rtl/bist_misr.sv
module bist_misr
    import bist_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_load,
    input  logic        absorb,
    input  logic [15:0] data,
    output logic [15:0] sig,
    output logic [15:0] sig_next
);
    logic [15:0] sig_q;

    assign sig_next = misr_step(sig_q, data);
    assign sig      = sig_q;

    always_ff @(posedge clk) begin
        if (rst || seed_load) begin
            sig_q <= MISR_SEED;
        end else if (absorb) begin
            sig_q <= sig_next;
        end
    end
endmodule

// File: rtl/bist_diag_wait.sv
module bist_diag_wait #(
    parameter int unsigned TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic active,
    input  logic reply,
    input  logic reply_fail,
    output logic finished,
    output logic result_fail
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign finished    = active && (reply || cnt_q == LAST);
    assign result_fail = reply ? reply_fail : 1'b1;
endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned ROM_DEPTH = 64,
    parameter int unsigned REG_COUNT = 8,
    parameter int unsigned TIMEOUT   = 1024,
    parameter logic [15:0] GOLDEN    = 16'h0000,
    localparam int unsigned RA_W     = $clog2(ROM_DEPTH),
    localparam int unsigned RI_W     = $clog2(REG_COUNT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   start_addr,
    output logic            busy,
    output logic            sel_rst,
    output logic            rom_rd,
    output logic [RA_W-1:0] rom_addr,
    input  logic [15:0]     rom_data,
    output logic            reg_we,
    output logic [RI_W-1:0] reg_idx,
    output logic [15:0]     reg_wdata,
    input  logic [15:0]     reg_rdata,
    output logic            diag_req,
    input  logic            diag_done,
    input  logic            diag_fail,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [31:0]     wr_data,
    output logic            dev_rst
);
    localparam logic [RA_W-1:0] ROM_LAST = RA_W'(ROM_DEPTH - 1);
    localparam logic [RI_W-1:0] REG_LAST = RI_W'(REG_COUNT - 1);

    bist_state_e     state_q;
    logic [RA_W-1:0] rom_cnt_q;
    logic [RI_W-1:0] idx_q;
    logic            pat_q;
    logic [AW-1:0]   addr_q;
    bist_flags_t     flags_q;

    logic [15:0] misr_sig;
    logic [15:0] misr_next;
    logic        dg_finished;
    logic        dg_fail;

    bist_misr u_misr (
        .clk       (clk),
        .rst       (rst),
        .seed_load (state_q == ST_SELRST),
        .absorb    (state_q == ST_ROM),
        .data      (rom_data),
        .sig       (misr_sig),
        .sig_next  (misr_next)
    );

    bist_diag_wait #(.TIMEOUT(TIMEOUT)) u_diag (
        .clk         (clk),
        .rst         (rst),
        .arm         (state_q == ST_DIAG_REQ),
        .active      (state_q == ST_DIAG_WAIT),
        .reply       (diag_done),
        .reply_fail  (diag_fail),
        .finished    (dg_finished),
        .result_fail (dg_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rom_cnt_q <= '0;
            idx_q     <= '0;
            pat_q     <= 1'b0;
            addr_q    <= '0;
            flags_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        state_q <= ST_SELRST;
                    end
                end
                ST_SELRST: begin
                    rom_cnt_q <= '0;
                    idx_q     <= '0;
                    pat_q     <= 1'b0;
                    flags_q   <= '0;
                    state_q   <= ST_ROM;
                end
                ST_ROM: begin
                    rom_cnt_q <= rom_cnt_q + 1'b1;
                    if (rom_cnt_q == ROM_LAST) begin
                        flags_q.rom_fail <= (misr_next != GOLDEN);
                        state_q          <= ST_REG_WR;
                    end
                end
                ST_REG_WR: begin
                    state_q <= ST_REG_RD;
                end
                ST_REG_RD: begin
                    if (reg_rdata != reg_wdata) begin
                        flags_q.reg_fail <= 1'b1;
                    end
                    if (!pat_q) begin
                        pat_q   <= 1'b1;
                        state_q <= ST_REG_WR;
                    end else begin
                        pat_q <= 1'b0;
                        if (idx_q == REG_LAST) begin
                            state_q <= ST_DIAG_REQ;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_REG_WR;
                        end
                    end
                end
                ST_DIAG_REQ: begin
                    state_q <= ST_DIAG_WAIT;
                end
                ST_DIAG_WAIT: begin
                    if (dg_finished) begin
                        flags_q.diag_fail <= dg_fail;
                        state_q           <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    state_q <= ST_DEVRST;
                end
                ST_DEVRST: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign sel_rst   = (state_q == ST_SELRST);
    assign rom_rd    = (state_q == ST_ROM);
    assign rom_addr  = rom_cnt_q;
    assign reg_we    = (state_q == ST_REG_WR);
    assign reg_idx   = idx_q;
    assign reg_wdata = pat_q ? PAT_B : PAT_A;
    assign diag_req  = (state_q == ST_DIAG_REQ);
    assign wr_en     = (state_q == ST_WRITE);
    assign wr_addr   = addr_q;
    assign wr_data   = {misr_sig, pack_status(flags_q)};
    assign dev_rst   = (state_q == ST_DEVRST);
endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
    parameter int unsigned ROM_DEPTH = 64,
    parameter int unsigned REG_COUNT = 8,
    parameter int unsigned TIMEOUT   = 1024,
    localparam int unsigned RA_W     = $clog2(ROM_DEPTH),
    localparam int unsigned RI_W     = $clog2(REG_COUNT),
    localparam int unsigned WCW      = $clog2(TIMEOUT + 2)
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            sel_rst,
    input logic            rom_rd,
    input logic [RA_W-1:0] rom_addr,
    input logic            reg_we,
    input logic [RI_W-1:0] reg_idx,
    input logic            diag_req,
    input logic            wr_en,
    input logic [31:0]     wr_data,
    input logic            dev_rst
);
    logic           waiting_q;
    logic [WCW-1:0] wait_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting_q  <= 1'b0;
            wait_cnt_q <= '0;
        end else if (diag_req) begin
            waiting_q  <= 1'b1;
            wait_cnt_q <= '0;
        end else if (wr_en) begin
            waiting_q <= 1'b0;
        end else if (waiting_q) begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    a_r1_selrst_follows_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> sel_rst);
    a_r1_selrst_single: assert property (@(posedge clk) disable iff (rst)
        sel_rst |=> (!sel_rst && rom_rd));
    a_r2_rom_from_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_rd) |-> rom_addr == '0);
    a_r2_rom_step: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && $past(rom_rd)) |-> rom_addr == RA_W'($past(rom_addr) + 1'b1));
    a_r5_readback_slot: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (!reg_we && reg_idx == $past(reg_idx)));
    a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
        diag_req |=> !diag_req);
    a_r7_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        waiting_q |-> wait_cnt_q <= WCW'(TIMEOUT));
    a_r8_status_layout: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_data[15:0] & ~16'h102C) == 16'h0000 &&
                   wr_data[12] == (wr_data[5] | wr_data[3] | wr_data[2])));
    a_r9_reset_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dev_rst && !wr_en));
    a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        dev_rst |=> !busy);
    a_r10_start_only_from_idle: assert property (@(posedge clk) disable iff (rst)
        sel_rst |-> !$past(busy));
endmodule

bind bist_seq bist_seq_chk #(
    .ROM_DEPTH (ROM_DEPTH),
    .REG_COUNT (REG_COUNT),
    .TIMEOUT   (TIMEOUT)
) u_chk (.*);

// File: tb/bist_seq_test.sv
`timescale 1ns/1ps
module bist_seq_test;
    localparam int unsigned AW      = 32;
    localparam int unsigned DEPTH   = 64;
    localparam int unsigned NREG    = 8;
    localparam int unsigned TMO     = 1024;

    function automatic logic [15:0] rom_word(input int unsigned a, input bit flip);
        logic [15:0] w;
        w = 16'(a * 16'h2F3B) ^ 16'hC35A;
        if (flip && a == 5) w = w ^ 16'h0100;
        return w;
    endfunction

    function automatic logic [15:0] calc_sig(input bit flip);
        logic [15:0] s;
        s = 16'hFFFF;
        for (int i = 0; i < DEPTH; i++) begin
            s = ({s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000)) ^ rom_word(i, flip);
        end
        return s;
    endfunction

    localparam logic [15:0] GOLD = calc_sig(1'b0);

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [AW-1:0] start_addr = '0;
    logic busy, sel_rst, rom_rd, reg_we, diag_req, wr_en, dev_rst;
    logic [5:0]  rom_addr;
    logic [15:0] rom_data;
    logic [2:0]  reg_idx;
    logic [15:0] reg_wdata, reg_rdata;
    logic diag_done = 0, diag_fail = 0;
    logic [AW-1:0] wr_addr;
    logic [31:0] wr_data;

    always #10 clk = ~clk;

    bist_seq #(.AW(AW), .ROM_DEPTH(DEPTH), .REG_COUNT(NREG), .TIMEOUT(TMO), .GOLDEN(GOLD)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .busy(busy),
        .sel_rst(sel_rst), .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .diag_req(diag_req), .diag_done(diag_done), .diag_fail(diag_fail),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dev_rst(dev_rst)
    );

    // environment models
    bit rom_flip = 0;
    bit reg_stuck = 0;
    bit d_respond = 1;
    bit d_fail = 0;
    int d_delay = 3;
    logic [15:0] bank [NREG];

    assign rom_data  = rom_word(int'(rom_addr), rom_flip);
    assign reg_rdata = bank[reg_idx] | ((reg_stuck && reg_idx == 3'd3) ? 16'h0001 : 16'h0000);

    always @(posedge clk) if (reg_we) bank[reg_idx] <= reg_wdata;

    always begin
        @(negedge clk);
        if (diag_req && d_respond) begin
            repeat (d_delay) @(negedge clk);
            diag_done = 1;
            diag_fail = d_fail;
            @(negedge clk);
            diag_done = 0;
            diag_fail = 0;
        end
    end

    // monitor
    int checks = 0, errors = 0;
    int selrst_n, rom_n, rom_exp, reg_step, wr_n, dr_n, wr_cyc, dr_cyc, cyc;
    bit order_bad, rom_bad, reg_bad;
    logic [AW-1:0] wr_addr_c;
    logic [31:0] wr_data_c;

    task automatic mon_clear();
        selrst_n = 0; rom_n = 0; rom_exp = 0; reg_step = 0; wr_n = 0; dr_n = 0;
        order_bad = 0; rom_bad = 0; reg_bad = 0; wr_cyc = 0; dr_cyc = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (sel_rst) selrst_n++;
        if ((rom_rd || reg_we) && selrst_n == 0) order_bad = 1;
        if (rom_rd) begin
            if (int'(rom_addr) != rom_exp) rom_bad = 1;
            rom_exp++;
            rom_n++;
        end
        if (reg_we) begin
            if (int'(reg_idx) != reg_step / 2) reg_bad = 1;
            if (reg_wdata != ((reg_step % 2) ? 16'h5555 : 16'hAAAA)) reg_bad = 1;
            reg_step++;
        end
        if (wr_en) begin
            wr_n++; wr_addr_c = wr_addr; wr_data_c = wr_data; wr_cyc = cyc;
        end
        if (dev_rst) begin
            dr_n++; dr_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status(input bit r, input bit m, input bit d);
        logic [15:0] w;
        w = '0;
        w[2] = r; w[3] = m; w[5] = d; w[12] = r | m | d;
        return w;
    endfunction

    task automatic run_case(input string name, input logic [AW-1:0] addr,
                            input bit flip, input bit stuck, input bit resp, input bit dfail,
                            input int delay, input bit restart,
                            input bit er, input bit em, input bit ed);
        int guard;
        rom_flip = flip; reg_stuck = stuck; d_respond = resp; d_fail = dfail; d_delay = delay;
        mon_clear();
        @(negedge clk);
        start = 1; start_addr = addr;
        @(negedge clk);
        start = 0;
        if (restart) begin
            repeat (6) @(negedge clk);
            start = 1; start_addr = ~addr;
            @(negedge clk);
            start = 0;
            repeat (40) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
        end
        guard = 0;
        while (dr_n == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        $display("case %s", name);
        chk(selrst_n == 1 && !order_bad, "R1 selective reset pulse", 64'(selrst_n), 64'd1);
        chk(rom_n == DEPTH && !rom_bad, "R2 ROM address order", 64'(rom_n), 64'(DEPTH));
        chk(reg_step == 2 * NREG && !reg_bad, "R5 register pattern order", 64'(reg_step), 64'(2 * NREG));
        chk(wr_data_c[31:16] == calc_sig(flip), "R3 signature", 64'(wr_data_c[31:16]), 64'(calc_sig(flip)));
        chk(wr_data_c[15:0] == exp_status(er, em, ed), "R4 R5 R6 R7 R8 status",
            64'(wr_data_c[15:0]), 64'(exp_status(er, em, ed)));
        chk(wr_n == 1 && wr_addr_c == addr, "R9 R10 single write to start address",
            64'(wr_addr_c), 64'(addr));
        chk(dr_n == 1 && dr_cyc == wr_cyc + 1, "R9 device reset after write",
            64'(dr_cyc - wr_cyc), 64'd1);
        chk(busy == 1'b0, "R9 idle after device reset", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !sel_rst && !rom_rd && !reg_we && !diag_req && !wr_en && !dev_rst,
            "R9 reset state idle", 64'(busy), 64'd0);
        // clean pass, R3 R4 R8
        run_case("pass",        32'h0000_1000, 0, 0, 1, 0, 3, 0, 0, 0, 0);
        // ROM corruption, R4
        run_case("rom_fault",   32'h0000_2040, 1, 0, 1, 0, 3, 0, 1, 0, 0);
        // stuck register bit, R5
        run_case("reg_fault",   32'h0000_3080, 0, 1, 1, 0, 3, 0, 0, 1, 0);
        // failing diagnose reply, R6
        run_case("diag_fail",   32'h0000_40C0, 0, 0, 1, 1, 3, 0, 0, 0, 1);
        // silent responder, R7 timeout
        run_case("diag_silent", 32'h0000_5100, 0, 0, 0, 0, 3, 0, 0, 0, 1);
        // reply in final wait cycle honoured, R7
        run_case("diag_edge",   32'h0000_6140, 0, 0, 1, 0, TMO, 0, 0, 0, 0);
        // reply one cycle late is a timeout, R7
        run_case("diag_late",   32'h0000_7180, 0, 0, 1, 0, TMO + 1, 0, 0, 0, 1);
        // restart while busy ignored with combined faults, R10
        run_case("restart",     32'h0000_81C0, 1, 1, 1, 0, 3, 1, 1, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule